// File: doc/BRIEF.md
# Periodic Battery Load-Test Scheduler

This block decides when a backup battery is put under a test load and whether the result raises a battery-warning output. While main power is good, it counts a long interval. When the interval ends, it raises a load-enable strobe for a fixed number of cycles. During that window it watches a digital flag from an external comparator, which goes high when the battery reads below its trip level. The analog load and the comparator sit outside the block.

Every power-up forces a fresh test once the system signals that its recovery time has elapsed. This happens even when the warning is already set. A periodic test can only set the warning; it never clears it. A power-up test that finds a good battery clears the warning. After any completed test the interval count starts again from zero.

A loss of main power stops everything. The load is removed, a test in progress is dropped without any effect on the warning, and the interval count is discarded. The warning drives an open-drain style pull-down enable: high means the pin is pulled low, and low means the pin is left floating.

Top module: `batt_test_sched`

## Requirements
- R1: A synchronous reset turns the load off, releases the warning and leaves the controller waiting for main power.
- R2: After `pwr_ok` rises, no test starts until `rec_done` is seen high while `pwr_ok` is high. `load_en` then rises on the next clock edge, and a `rec_done` that is high while power is bad has no effect.
- R3: Each test holds `load_en` high for exactly `TEST_CYC` consecutive cycles, unless power fails.
- R4: After a completed test, `load_en` stays low for exactly `INTERVAL_CYC` cycles, and then the next periodic test begins.
- R5: If `bat_low` is sampled high in any cycle while `load_en` is high, including the last cycle, `warn_pull_low` is 1 (pin pulled low) from the edge that ends the window onward.
- R6: A periodic test with no low sample leaves an active warning active.
- R7: A power-up test with no low sample clears the warning (`warn_pull_low` = 0, pin floating) at the edge that ends the window.
- R8: When `pwr_ok` is low, `load_en` is low from the next edge onward. A test in progress is aborted with the warning unchanged, and the interval count restarts.
- R9: `bat_low` is ignored whenever `load_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Main supply within tolerance |
| rec_done | input | 1 | Recovery time has elapsed since the supply came up |
| bat_low | input | 1 | Comparator flag: battery below trip level |
| load_en | output | 1 | Connects the test load to the battery |
| warn_pull_low | output | 1 | Enable for the open-drain warning pull-down (1 = pin driven low) |

## Verification
Every result is registered. `load_en` therefore changes on the first clock edge after the input that causes the change. `warn_pull_low` changes on the same edge that drops `load_en` at the end of a window. The bench drives inputs at the falling edge and checks outputs at the following falling edge, one row per cycle. Window and interval lengths are shortened to 3 and 6 cycles, so every window boundary and every interval boundary falls on a known row.

// File: rtl/bts_pkg.sv
package bts_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RECOV = 2'd1,
        ST_IDLE  = 2'd2,
        ST_TEST  = 2'd3
    } sched_state_e;

    typedef enum logic {
        TK_POWERUP  = 1'b0,
        TK_PERIODIC = 1'b1
    } test_kind_e;

    typedef struct packed {
        logic       sample;
        logic       commit;
        test_kind_e kind;
    } test_ctl_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Outcome of a finished test: a trip always sets the warning; only a
    // clean power-up test clears it; a clean periodic test leaves it.
    function automatic logic resolve_warn(input logic tripped,
                                          input test_kind_e kind,
                                          input logic cur);
        if (tripped)
            return 1'b1;
        if (kind == TK_POWERUP)
            return 1'b0;
        return cur;
    endfunction

endpackage

// File: rtl/bts_cycle_timer.sv
module bts_cycle_timer #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int unsigned W = bts_pkg::cnt_width(LEN);
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);

    // Count restarts from zero whenever the timer is idle (R8).
    assert_idle_clears_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));

    // The count never passes its last value (R3, R4).
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/bts_warn_latch.sv
module bts_warn_latch
    import bts_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  test_ctl_t ctl,
    input  logic      bat_low,
    output logic      warn
);
    logic hit_q;
    logic warn_q;
    logic tripped;

    assign tripped = hit_q | bat_low;

    always_ff @(posedge clk) begin
        if (rst || !ctl.sample)
            hit_q <= 1'b0;
        else
            hit_q <= tripped;
    end

    always_ff @(posedge clk) begin
        if (rst)
            warn_q <= 1'b0;
        else if (ctl.commit)
            warn_q <= resolve_warn(tripped, ctl.kind, warn_q);
    end

    assign warn = warn_q;

    // A low reading in the final window cycle still trips (R5).
    assert_last_sample_trips_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.commit && bat_low) |=> warn_q);

    // A clean periodic test leaves the warning alone (R6).
    assert_periodic_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl.commit && ctl.kind == TK_PERIODIC && warn_q) |=> warn_q);

    // A clean power-up test releases the warning (R7).
    assert_powerup_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl.commit && ctl.kind == TK_POWERUP && !tripped) |=> !warn_q);
endmodule

// File: rtl/batt_test_sched.sv
module batt_test_sched
    import bts_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = 32'd2_831_155_200,
    parameter int unsigned TEST_CYC     = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic rec_done,
    input  logic bat_low,
    output logic load_en,
    output logic warn_pull_low
);
    sched_state_e st_q, st_d;
    test_kind_e   kind_q, kind_d;
    logic         win_done, ivl_done;
    test_ctl_t    ctl;
    logic         warn;

    bts_cycle_timer #(.LEN(TEST_CYC)) u_win (
        .clk (clk),
        .rst (rst),
        .run (st_q == ST_TEST),
        .done(win_done)
    );

    bts_cycle_timer #(.LEN(INTERVAL_CYC)) u_ivl (
        .clk (clk),
        .rst (rst),
        .run (st_q == ST_IDLE),
        .done(ivl_done)
    );

    always_comb begin
        st_d   = st_q;
        kind_d = kind_q;
        if (!pwr_ok) begin
            st_d = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF:   st_d = ST_RECOV;
                ST_RECOV: if (rec_done) begin
                              st_d   = ST_TEST;
                              kind_d = TK_POWERUP;
                          end
                ST_TEST:  if (win_done) st_d = ST_IDLE;
                ST_IDLE:  if (ivl_done) begin
                              st_d   = ST_TEST;
                              kind_d = TK_PERIODIC;
                          end
                default:  st_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_OFF;
            kind_q <= TK_POWERUP;
        end else begin
            st_q   <= st_d;
            kind_q <= kind_d;
        end
    end

    assign ctl.sample = (st_q == ST_TEST) && pwr_ok;
    assign ctl.commit = ctl.sample && win_done;
    assign ctl.kind   = kind_q;

    bts_warn_latch u_warn (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .bat_low(bat_low),
        .warn   (warn)
    );

    assign load_en       = (st_q == ST_TEST);
    assign warn_pull_low = warn;

    // Load drops one edge after power is lost (R8).
    assert_no_load_unpowered_R8: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> !load_en);

    // An aborted test leaves the warning untouched (R8).
    assert_abort_keeps_warn_R8: assert property (@(posedge clk) disable iff (rst)
        (load_en && !pwr_ok) |=> $stable(warn_pull_low));

    // Outside a window the comparator cannot move the warning (R9).
    assert_idle_ignores_flag_R9: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(warn_pull_low));

    // No test starts before recovery is reported (R2).
    assert_wait_recovery_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RECOV && !rec_done) |=> !load_en);
endmodule

// File: tb/batt_test_sched_tb.sv
`timescale 1ns/1ps
module batt_test_sched_tb;
    localparam int unsigned IVL = 6;
    localparam int unsigned WIN = 3;
    localparam int unsigned NV  = 35;

    logic clk = 1'b0;
    logic rst, pwr_ok, rec_done, bat_low;
    logic load_en, warn_pull_low;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #2 clk = ~clk;

    batt_test_sched #(.INTERVAL_CYC(IVL), .TEST_CYC(WIN)) u_dut (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .rec_done(rec_done),
        .bat_low(bat_low), .load_en(load_en), .warn_pull_low(warn_pull_low)
    );

    // Row: {req, pwr_ok, rec_done, bat_low, expected load_en, expected warn}
    localparam logic [8:0] VEC [NV] = '{
        {4'd2, 5'b10000},                       // R2 power up, waiting
        {4'd2, 5'b11010},                       // R2 recovery -> test
        {4'd3, 5'b11110},                       // R3 low sample in window
        {4'd3, 5'b10010},                       // R3
        {4'd5, 5'b10001},                       // R5 window ends, warn set
        {4'd4, 5'b10001}, {4'd4, 5'b10001},     // R4 interval
        {4'd4, 5'b10001}, {4'd4, 5'b10001},
        {4'd4, 5'b10001},
        {4'd4, 5'b10011},                       // R4 periodic test starts
        {4'd6, 5'b10011}, {4'd6, 5'b10011},     // R6 clean samples
        {4'd6, 5'b10001},                       // R6 warn stays
        {4'd8, 5'b00001},                       // R8 power lost
        {4'd2, 5'b10001},                       // R2 waiting recovery
        {4'd2, 5'b11011},                       // R2 power-up test
        {4'd7, 5'b10011}, {4'd7, 5'b10011},
        {4'd7, 5'b10000},                       // R7 clean power-up clears
        {4'd9, 5'b10100}, {4'd9, 5'b10100},     // R9 flag high while idle
        {4'd9, 5'b10100}, {4'd9, 5'b10100},
        {4'd9, 5'b10100},
        {4'd4, 5'b10110},                       // R4 next periodic test
        {4'd9, 5'b10110},                       // low sample in window
        {4'd8, 5'b00000},                       // R8 abort, warn unchanged
        {4'd8, 5'b01000},                       // R8 recovery ignored unpowered
        {4'd2, 5'b10000}, {4'd2, 5'b10000},     // R2 waiting
        {4'd2, 5'b11010},                       // R2 test
        {4'd5, 5'b10010}, {4'd5, 5'b10010},
        {4'd5, 5'b10101}                        // R5 last-cycle trip
    };

    task automatic check(input int req, input logic act, input logic exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step(input int req, input logic p, input logic r,
                        input logic b, input logic el, input logic ew);
        pwr_ok = p; rec_done = r; bat_low = b;
        @(negedge clk);
        check(req, load_en, el, "load_en");
        check(req, warn_pull_low, ew, "warn_pull_low");
    endtask

    initial begin
        rst = 1'b1; pwr_ok = 1'b0; rec_done = 1'b0; bat_low = 1'b0;
        repeat (3) @(negedge clk);
        check(1, load_en, 1'b0, "reset load_en");        // R1
        check(1, warn_pull_low, 1'b0, "reset warn");     // R1
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            step(int'(VEC[i][8:5]), VEC[i][4], VEC[i][3], VEC[i][2],
                 VEC[i][1], VEC[i][0]);

        // R5: power-up test with bad battery keeps warning
        step(8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        step(2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        step(2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        step(5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        step(5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        step(5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        // R8: power loss mid-interval, then R2 waits for recovery
        step(4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        step(4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        step(8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 8; k++)
            step(2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        // R8: interval restarted, full count needed after next test
        step(2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        step(3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        step(3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        step(7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 5; k++)
            step(4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step(4, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        step(5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        step(5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        step(5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        // R1: reset while warning is active
        rst = 1'b1;
        step(1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        step(1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        step(1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual hung expected finish");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule